// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends words on one serial data pin, timed by a shift clock that another device drives. It does not make its own bit clock. The external clock is brought into the system clock domain by a two-flop synchronizer, and the shift register moves when an edge is detected there. The shift clock comes from outside the block, so the bit timing does not depend on any local bit-rate generator.

A host writes words into a holding register that is one word deep. If the shift register is idle, the held word moves into it on the next cycle and the holding register reports empty again. If a word is still shifting, a second write waits in the holding register. It moves only when the current word has finished, and only then does the buffer-empty flag rise. The flag drives an interrupt output when the interrupt enable is set. An optional ninth bit can be appended to each word. A write that arrives while the holding register is full is dropped, and a sticky error flag records it.

The pin is half duplex. It is shared with a receiver outside this block, so transmission runs only when the port enable, the synchronous mode select and the transmit enable are all set, master mode is cleared and both receive enables are cleared.

Top module: `sync_slave_tx`

## Requirements
- R1: Transmission is active only when `port_en`, `sync_mode` and `tx_en` are 1 and `master_mode`, `rx_single` and `rx_cont` are 0. While inactive, `tx_pin` is held at 1, no word moves into the shift register, and a word that is shifting is abandoned.
- R2: A write accepted while the shift register is idle and the block is active moves into the shift register on the second clock after the write. `hold_empty` is then 1 again and `tx_pin` shows bit 0 of the word.
- R3: Bits leave the block least significant first. `tx_pin` advances to the next bit only on a falling edge of the effective shift clock, and it holds its value across the rising edge.
- R4: A word written while another word is shifting stays in the holding register, and `hold_empty` stays 0. After the final falling edge of the current word, the held word moves into the shift register, and only then does `hold_empty` return to 1.
- R5: `irq_out` is 1 exactly when `hold_empty` is 1 and `irq_en` is 1.
- R6: When `nine_bit` is 1 at load time, a ninth bit equal to the value of `bit8_val` at load is sent after the eight data bits. Otherwise a word is eight bits long.
- R7: The effective shift clock is `ext_sclk` XOR `clk_inv`.
- R8: `shift_empty` is 1 while no word is in the shift register. It falls when a word is loaded and returns to 1 on the falling edge that ends the word's last bit. At that point `tx_pin` returns to 1.
- R9: A write while the holding register is full is discarded: the held word is sent unchanged. The write sets `overrun`, which stays 1 until reset.
- R10: After reset `hold_empty` is 1, `shift_empty` is 1, `overrun` is 0 and `tx_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sclk | input | 1 | Externally supplied shift clock |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| master_mode | input | 1 | Master clock mode (must be 0) |
| tx_en | input | 1 | Transmit enable |
| rx_single | input | 1 | Single receive enable (must be 0) |
| rx_cont | input | 1 | Continuous receive enable (must be 0) |
| clk_inv | input | 1 | Shift clock polarity inversion |
| nine_bit | input | 1 | Send a ninth bit with each word |
| bit8_val | input | 1 | Value of the ninth bit |
| irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Word to write |
| tx_pin | output | 1 | Serial data pin |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq_out | output | 1 | Gated transmit interrupt / wake request |
| overrun | output | 1 | Sticky flag for a write to a full holding register |

## Verification
The assertions check the following on every cycle:
- the gating of `irq_out`;
- the pin staying idle while the port is inactive;
- `overrun` staying set once it has been set;
- a write to a full holding register setting `overrun`;
- `hold_empty` rising only in the cycle after a word moves into the shifter;
- a load always leaving the shifter busy;
- the pin changing only at a load or at a detected shift edge.

Some behaviour can only be shown by the bench scenarios, because it depends on the actual bit values and on the order of several frames:
- the least-significant-first bit order;
- the ninth bit;
- clock polarity inversion;
- a held second word waiting and then going out whole;
- a discarded third word never reaching the pin.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CNT_W-1:0]   bitcnt_t;

  // number of bits on the wire for one word
  function automatic bitcnt_t frame_len(input logic nine);
    return nine ? bitcnt_t'(FRAME_W) : bitcnt_t'(DATA_W);
  endfunction

  // word with its optional top bit, LSB goes out first
  function automatic frame_t frame_pack(input logic [DATA_W-1:0] d,
                                        input logic nine, input logic b8);
    return {nine & b8, d};
  endfunction

  // all port configuration bits agree with slave transmission
  function automatic logic tx_allowed(input logic pen, input logic syn,
                                      input logic mst, input logic ten,
                                      input logic rxs, input logic rxc);
    return pen & syn & ~mst & ten & ~rxs & ~rxc;
  endfunction
endpackage

// File: rtl/sts_clk_sync.sv
module sts_clk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_clk,
  input  logic invert,
  output logic fall_evt
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              eff;

  // idle level of the external clock reads as high after the XOR
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_clk};
      prev_q <= eff;
    end
  end

  assign eff      = sync_q[LAST] ^ invert;
  assign fall_evt = prev_q & ~eff;
endmodule

// File: rtl/sts_hold_reg.sv
module sts_hold_reg
  import sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] word,
  output logic              ovr
);
  logic accept;
  assign accept = wr_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
      ovr  <= 1'b0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        word <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
      if (wr_valid && full) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/sts_shifter.sv
module sts_shifter
  import sts_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  logic   load,
  input  frame_t load_frame,
  input  logic   load_nine,
  input  logic   shift,
  output logic   busy,
  output logic   pin
);
  frame_t  sreg;
  bitcnt_t left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (!active) begin
      busy <= 1'b0;
    end else if (load) begin
      sreg <= load_frame;
      left <= frame_len(load_nine) - bitcnt_t'(1);
      busy <= 1'b1;
    end else if (shift && busy) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        sreg <= sreg >> 1;
        left <= left - bitcnt_t'(1);
      end
    end
  end

  assign pin = (active && busy) ? sreg[0] : 1'b1;
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sts_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sclk,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_mode,
  input  logic              tx_en,
  input  logic              rx_single,
  input  logic              rx_cont,
  input  logic              clk_inv,
  input  logic              nine_bit,
  input  logic              bit8_val,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_pin,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq_out,
  output logic              overrun
);
  // named internal events, observed by the bound checker
  logic              active;
  logic              load_evt;
  logic              shift_evt;
  logic              hold_full;
  logic              sh_busy;
  logic [DATA_W-1:0] held_word;

  assign active   = tx_allowed(port_en, sync_mode, master_mode, tx_en,
                               rx_single, rx_cont);
  assign load_evt = active & hold_full & ~sh_busy;

  sts_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_clk  (ext_sclk),
    .invert   (clk_inv),
    .fall_evt (shift_evt)
  );

  sts_hold_reg u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (load_evt),
    .full     (hold_full),
    .word     (held_word),
    .ovr      (overrun)
  );

  sts_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .load       (load_evt),
    .load_frame (frame_pack(held_word, nine_bit, bit8_val)),
    .load_nine  (nine_bit),
    .shift      (shift_evt),
    .busy       (sh_busy),
    .pin        (tx_pin)
  );

  assign hold_empty  = ~hold_full;
  assign shift_empty = ~sh_busy;
  assign irq_out     = irq_en & hold_empty;
endmodule

// File: rtl/sts_checker.sv
module sts_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic load_evt,
  input logic shift_evt,
  input logic wr_valid,
  input logic irq_en,
  input logic tx_pin,
  input logic hold_empty,
  input logic shift_empty,
  input logic irq_out,
  input logic overrun
);
  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_out);

  assert_pin_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> tx_pin);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_full_write_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !hold_empty) |=> overrun);

  assert_empty_after_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(load_evt));

  assert_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !shift_empty);

  assert_pin_moves_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load_evt && !shift_evt) |=> (!active || $stable(tx_pin)));
endmodule

bind sync_slave_tx sts_checker u_sts_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .active      (active),
  .load_evt    (load_evt),
  .shift_evt   (shift_evt),
  .wr_valid    (wr_valid),
  .irq_en      (irq_en),
  .tx_pin      (tx_pin),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty),
  .irq_out     (irq_out),
  .overrun     (overrun)
);

// File: tb/test_sync_slave_tx.sv
`timescale 1ns/1ps
module test_sync_slave_tx;
  localparam int H = 8;            // half period of the external clock, in clk cycles
  localparam int NV = 5;

  // vector: {irq_en, clk_inv, bit8, nine, data[7:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'h0_A5, 12'h8_3C, 12'h3_96, 12'h6_01, 12'hD_E7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_sclk = 1'b1, port_en = 1'b0, sync_mode = 1'b1, master_mode = 1'b0;
  logic tx_en = 1'b1, rx_single = 1'b0, rx_cont = 1'b0, clk_inv = 1'b0;
  logic nine_bit = 1'b0, bit8_val = 1'b0, irq_en = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic tx_pin, hold_empty, shift_empty, irq_out, overrun;

  int checks = 0, failures = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  sync_slave_tx i_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .ext_sclk(ext_sclk), .port_en(port_en),
    .sync_mode(sync_mode), .master_mode(master_mode), .tx_en(tx_en),
    .rx_single(rx_single), .rx_cont(rx_cont), .clk_inv(clk_inv),
    .nine_bit(nine_bit), .bit8_val(bit8_val), .irq_en(irq_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .tx_pin(tx_pin),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .irq_out(irq_out),
    .overrun(overrun));

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", what, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_eff(input logic v);
    ext_sclk = v ^ clk_inv;
  endtask

  task automatic write(input logic [7:0] d);
    wr_data = d; wr_valid = 1'b1;
    cyc(1);
    wr_valid = 1'b0;
  endtask

  // expects the word already loaded; leaves shifter empty
  task automatic run_frame(input logic [8:0] exp, input int n, input string tag);
    chk(tx_pin, exp[0], $sformatf("%s R3 bit0", tag));
    for (int i = 1; i < n; i++) begin
      set_eff(1'b0); cyc(H);
      chk(tx_pin, exp[i], $sformatf("%s R3 bit%0d after fall", tag, i));
      set_eff(1'b1); cyc(H);
      chk(tx_pin, exp[i], $sformatf("%s R3 bit%0d held over rise", tag, i));
    end
    set_eff(1'b0); cyc(H);
    set_eff(1'b1); cyc(H);
  endtask

  initial begin
    cyc(3);
    chk(hold_empty, 1'b1, "R10 hold_empty reset");
    chk(shift_empty, 1'b1, "R10 shift_empty reset");
    chk(overrun, 1'b0, "R10 overrun reset");
    chk(tx_pin, 1'b1, "R10 pin reset");
    rst_n = 1'b1;
    port_en = 1'b1;
    cyc(4);

    // table of configurations walked by one loop
    for (int v = 0; v < NV; v++) begin
      logic [11:0] e;
      int n;
      e = VEC[v];
      irq_en = e[11]; clk_inv = e[10]; bit8_val = e[9]; nine_bit = e[8];
      set_eff(1'b1);          // R7: effective clock high at rest
      cyc(6);
      n = e[8] ? 9 : 8;
      write(e[7:0]);
      cyc(3);
      chk(hold_empty, 1'b1, $sformatf("v%0d R2 moved to shifter", v));
      chk(shift_empty, 1'b0, $sformatf("v%0d R8 shifter loaded", v));
      chk(irq_out, e[11], $sformatf("v%0d R5 irq gating", v));
      run_frame({e[9] & e[8], e[7:0]}, n, $sformatf("v%0d R6 R7", v));
      chk(shift_empty, 1'b1, $sformatf("v%0d R8 empty after last bit", v));
      chk(tx_pin, 1'b1, $sformatf("v%0d R8 pin idle after word", v));
    end

    // held second word and a dropped third word
    clk_inv = 1'b0; nine_bit = 1'b0; irq_en = 1'b1; set_eff(1'b1);
    cyc(6);
    write(8'h3C);
    cyc(3);
    write(8'h5A);
    cyc(1);
    chk(hold_empty, 1'b0, "R4 second word held");
    chk(irq_out, 1'b0, "R5 irq low while held");
    write(8'hFF);
    cyc(1);
    chk(overrun, 1'b1, "R9 overrun set");
    run_frame(9'h03C, 8, "R4 first word");
    chk(hold_empty, 1'b1, "R4 hold empty after move");
    chk(shift_empty, 1'b0, "R4 second word loaded");
    run_frame(9'h05A, 8, "R9 held word unchanged");
    chk(shift_empty, 1'b1, "R8 empty after second");
    chk(overrun, 1'b1, "R9 overrun sticky");

    // receive enable blocks transmission
    rx_cont = 1'b1;
    cyc(2);
    write(8'hC3);
    cyc(4);
    chk(shift_empty, 1'b1, "R1 no load while receive enabled");
    chk(hold_empty, 1'b0, "R1 word waits in holding");
    set_eff(1'b0); cyc(H);
    chk(tx_pin, 1'b1, "R1 pin idle while inactive");
    set_eff(1'b1); cyc(H);
    rx_cont = 1'b0;
    cyc(4);
    chk(shift_empty, 1'b0, "R1 load after receive cleared");
    run_frame(9'h0C3, 8, "R1 released word");

    // disabling mid-word abandons it
    write(8'h00);
    cyc(4);
    chk(tx_pin, 1'b0, "R2 bit0 of zero word");
    port_en = 1'b0;
    cyc(2);
    chk(tx_pin, 1'b1, "R1 pin idle when disabled");
    chk(shift_empty, 1'b1, "R1 word abandoned");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule